// File: doc/BRIEF.md
# Interval Timer Access Port

This block is the byte-wide register front end of a three-channel interval timer. A host drives a 2-bit address together with write and read strobes and 8-bit data. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port. Control words configure a channel, freeze its count for reading, or capture a snapshot of several channels at once. The counting logic itself sits outside this block.

The block assembles 16-bit initial counts from one or two byte writes. It sends each finished count to its channel as a one-cycle load strobe together with the count value. It also presents each channel's mode and BCD selection as steady outputs. On the read side, it returns bytes of the live count sampled from the channel, or a frozen count, or a status byte. Frozen values take priority over live ones, and a status byte takes priority over a frozen count.

Top module: `tmr_access_port`

## Requirements
- R1: A control-port write whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero configures that channel. Bits 5:4 set the access mode: 1 is low byte only, 2 is high byte only, 3 is low byte then high byte. Bits 3:1 set the counting mode, with codes 6 and 7 folded to 2 and 3. Bit 0 sets BCD. The new mode and BCD appear on `ch_mode` and `ch_bcd` from the next cycle.
- R2: In low-only access, a data write loads the count {8'h00, byte}. In high-only access, it loads {byte, 8'h00}. A load shows as `ch_load[n]` high for exactly the one cycle after the write, with the value on `ch_load_val[n]`.
- R3: In word access, the first data write is held and loads nothing. The second write loads {second, first}. The next write is again treated as a low byte.
- R4: A control word with bits 5:4 = 0 freezes that channel's current count. The frozen count is read as one byte in single-byte access (low or high byte as configured), or as the low byte then the high byte in word access. The freeze is released after its last byte.
- R5: A freeze request or status-capture request for a channel has no effect while an earlier frozen count or status of that channel is still unread.
- R6: A control word with bits 7:6 = 3 is a snapshot command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low freezes the count of each selected channel and bit 4 low captures its status. Channels that are not selected are unaffected.
- R7: The status byte is {OUT, null-count, access[1:0], mode[2:0], BCD}. OUT is sampled at capture time. A pending status is returned by the next read of that channel, which clears it. A frozen count is returned only by the reads that follow.
- R8: With nothing frozen or captured, reads return the live count. Low-only access returns the low byte and high-only access returns the high byte. Word access alternates low and high bytes, starting with low. A read of address 3 returns 0.
- R9: A control word with a nonzero access field returns both the write and read byte sequences of that channel to their first byte.
- R10: The null-count flag is set by a configuring control word and by every count load. It is cleared by a `ch_loaded[n]` pulse. When a set and a clear fall in the same cycle, the set wins.
- R11: After reset, every channel is in word access, mode 0 and binary, with null-count set. Nothing is frozen or captured, and no load strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | 0 to 2 select a channel data port, 3 the control port |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe; advances the read sequence at the clock edge |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for the current address, valid during the read cycle |
| ch_load | output | 3 | One-cycle count load strobe per channel |
| ch_load_val | output | 3x16 | Count delivered with the load strobe |
| ch_mode | output | 3x3 | Counting mode per channel |
| ch_bcd | output | 3 | BCD select per channel |
| ch_count | input | 3x16 | Live count from each channel |
| ch_out | input | 3 | OUT level from each channel |
| ch_loaded | input | 3 | Pulse from a channel when it has taken a new count |

## Verification
The one real same-cycle collision is at the null-count flag. A channel reports that it has taken its count in the same cycle that the host completes the next count write. The bench provokes this by raising `ch_loaded` in the same cycle as the final byte of a load. It then judges the outcome by capturing status and requiring bit 6 to read 1. A lone acknowledge, made later, must read 0. A second area of overlap is the read side. A captured status and a frozen count can both be pending on one channel, and the bench checks that they come back in the order status first, frozen bytes next, live count last.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int NCH   = 3;
    localparam int CNT_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } chcfg_t;

    typedef struct packed {
        logic   set_cfg;
        chcfg_t cfg;
        logic   cnt_frz;
        logic   st_cap;
    } chcmd_t;

    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic logic [7:0] status_byte(input logic out, input logic nul,
                                               input chcfg_t c);
        return {out, nul, c.acc, c.mode, c.bcd};
    endfunction

endpackage

// File: rtl/tap_ctrl_decode.sv
module tap_ctrl_decode
    import tap_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                 ctl_stb,
    input  logic [7:0]           ctl_byte,
    output chcmd_t [N-1:0]       cmd
);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cmd[i]         = '0;
            cmd[i].cfg.acc  = acc_e'(ctl_byte[5:4]);
            cmd[i].cfg.mode = fold_mode(ctl_byte[3:1]);
            cmd[i].cfg.bcd  = ctl_byte[0];
            if (ctl_stb) begin
                if (ctl_byte[7:6] == 2'd3) begin
                    if (ctl_byte[i+1]) begin
                        cmd[i].cnt_frz = !ctl_byte[5];
                        cmd[i].st_cap  = !ctl_byte[4];
                    end
                end else if (ctl_byte[7:6] == 2'(i)) begin
                    if (ctl_byte[5:4] == 2'd0)
                        cmd[i].cnt_frz = 1'b1;
                    else
                        cmd[i].set_cfg = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tap_channel.sv
module tap_channel
    import tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chcmd_t            cmd,
    input  logic              dwr,
    input  logic              drd,
    input  logic [7:0]        wbyte,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              out_in,
    input  logic              loaded_in,
    output logic [7:0]        rbyte,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output chcfg_t            cfg
);

    chcfg_t             cfg_q;
    logic               wr_hi_q, rd_hi_q;
    logic [7:0]         wlat_q;
    logic [CNT_W-1:0]   frz_q;
    acc_e               frz_st_q;
    logic [7:0]         st_q;
    logic               st_v_q;
    logic               null_q;
    logic               load_q;
    logic [CNT_W-1:0]   loadv_q;

    assign cfg      = cfg_q;
    assign load_stb = load_q;
    assign load_val = loadv_q;

    always_comb begin
        if (st_v_q)
            rbyte = st_q;
        else if (frz_st_q != ACC_NONE)
            rbyte = (frz_st_q == ACC_HI) ? frz_q[15:8] : frz_q[7:0];
        else begin
            case (cfg_q.acc)
                ACC_HI:   rbyte = cnt_in[15:8];
                ACC_WORD: rbyte = rd_hi_q ? cnt_in[15:8] : cnt_in[7:0];
                default:  rbyte = cnt_in[7:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};
            wr_hi_q  <= 1'b0;
            rd_hi_q  <= 1'b0;
            wlat_q   <= '0;
            frz_q    <= '0;
            frz_st_q <= ACC_NONE;
            st_q     <= '0;
            st_v_q   <= 1'b0;
            null_q   <= 1'b1;
            load_q   <= 1'b0;
            loadv_q  <= '0;
        end else begin
            load_q <= 1'b0;
            if (loaded_in)
                null_q <= 1'b0;
            if (cmd.set_cfg) begin
                cfg_q   <= cmd.cfg;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
                null_q  <= 1'b1;
            end
            if (cmd.cnt_frz && frz_st_q == ACC_NONE) begin
                frz_q    <= cnt_in;
                frz_st_q <= cfg_q.acc;
            end
            if (cmd.st_cap && !st_v_q) begin
                st_q   <= status_byte(out_in, null_q, cfg_q);
                st_v_q <= 1'b1;
            end
            if (drd) begin
                if (st_v_q)
                    st_v_q <= 1'b0;
                else if (frz_st_q != ACC_NONE)
                    frz_st_q <= (frz_st_q == ACC_WORD) ? ACC_HI : ACC_NONE;
                else if (cfg_q.acc == ACC_WORD)
                    rd_hi_q <= !rd_hi_q;
            end
            if (dwr) begin
                case (cfg_q.acc)
                    ACC_HI: begin
                        load_q  <= 1'b1;
                        loadv_q <= {wbyte, 8'h00};
                        null_q  <= 1'b1;
                    end
                    ACC_WORD: begin
                        if (!wr_hi_q) begin
                            wlat_q  <= wbyte;
                            wr_hi_q <= 1'b1;
                        end else begin
                            load_q  <= 1'b1;
                            loadv_q <= {wbyte, wlat_q};
                            null_q  <= 1'b1;
                            wr_hi_q <= 1'b0;
                        end
                    end
                    default: begin
                        load_q  <= 1'b1;
                        loadv_q <= {8'h00, wbyte};
                        null_q  <= 1'b1;
                    end
                endcase
            end
        end
    end

    assert_status_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (drd && st_v_q) |=> !st_v_q);

    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (frz_st_q != ACC_NONE && cmd.cnt_frz) |=> $stable(frz_q));

    assert_seq_restart_R9: assert property (@(posedge clk) disable iff (rst)
        cmd.set_cfg |=> (!wr_hi_q && !rd_hi_q));

    assert_null_on_load_R10: assert property (@(posedge clk) disable iff (rst)
        load_q |-> null_q);

endmodule

// File: rtl/tmr_access_port.sv
module tmr_access_port
    import tap_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   addr,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [7:0]                   wr_data,
    output logic [7:0]                   rd_data,
    output logic [NCH-1:0]               ch_load,
    output logic [NCH-1:0][CNT_W-1:0]    ch_load_val,
    output logic [NCH-1:0][2:0]          ch_mode,
    output logic [NCH-1:0]               ch_bcd,
    input  logic [NCH-1:0][CNT_W-1:0]    ch_count,
    input  logic [NCH-1:0]               ch_out,
    input  logic [NCH-1:0]               ch_loaded
);

    localparam logic [1:0] CTL_ADDR = 2'd3;

    chcmd_t [NCH-1:0]        cmd;
    logic   [NCH-1:0][7:0]   rbytes;
    chcfg_t [NCH-1:0]        cfgs;

    tap_ctrl_decode #(.N(NCH)) u_dec (
        .ctl_stb  (wr_en && addr == CTL_ADDR),
        .ctl_byte (wr_data),
        .cmd      (cmd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tap_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd[g]),
            .dwr       (wr_en && addr == 2'(g)),
            .drd       (rd_en && addr == 2'(g)),
            .wbyte     (wr_data),
            .cnt_in    (ch_count[g]),
            .out_in    (ch_out[g]),
            .loaded_in (ch_loaded[g]),
            .rbyte     (rbytes[g]),
            .load_stb  (ch_load[g]),
            .load_val  (ch_load_val[g]),
            .cfg       (cfgs[g])
        );
        assign ch_mode[g] = cfgs[g].mode;
        assign ch_bcd[g]  = cfgs[g].bcd;

        assert_load_from_write_R2: assert property (@(posedge clk) disable iff (rst)
            ch_load[g] |-> $past(wr_en && addr == 2'(g)));
    end

    always_comb begin
        case (addr)
            2'd0:    rd_data = rbytes[0];
            2'd1:    rd_data = rbytes[1];
            2'd2:    rd_data = rbytes[2];
            default: rd_data = 8'h00;
        endcase
    end

    assert_ctl_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == CTL_ADDR) |-> (rd_data == 8'h00));

    assert_single_load_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(ch_load) <= 1);

endmodule

// File: tb/sim_tmr_access_port.sv
module sim_tmr_access_port;

    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        addr;
    logic              wr_en, rd_en;
    logic [7:0]        wr_data, rd_data;
    logic [2:0]        ch_load;
    logic [2:0][15:0]  ch_load_val;
    logic [2:0][2:0]   ch_mode;
    logic [2:0]        ch_bcd;
    logic [2:0][15:0]  ch_count;
    logic [2:0]        ch_out;
    logic [2:0]        ch_loaded;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tmr_access_port u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .ch_load(ch_load),
        .ch_load_val(ch_load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_count(ch_count), .ch_out(ch_out), .ch_loaded(ch_loaded)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int fold(input int m);
        return (m > 5) ? m - 4 : m;
    endfunction

    function automatic int stat(input int o, input int nl, input int acc,
                                input int md, input int b);
        return (o << 7) | (nl << 6) | (acc << 4) | (md << 1) | b;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        addr = a; rd_en = 1'b1;
        #1;
        check(tag, int'(rd_data), exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ctl(input int ch, input int acc, input int md, input int b);
        wr(2'd3, 8'((ch << 6) | (acc << 4) | (md << 1) | b));
    endtask

    task automatic pulse_loaded(input int ch);
        ch_loaded[ch] = 1'b1;
        @(negedge clk);
        ch_loaded[ch] = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R11: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
        ch_count = '0; ch_out = '0; ch_loaded = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check("R11 load idle", int'(ch_load), 0);
        for (int c = 0; c < 3; c++) begin
            check("R11 mode", int'(ch_mode[c]), 0);
            check("R11 bcd", int'(ch_bcd[c]), 0);
            wr(2'd3, 8'(8'hE0 | (2 << c)));
            rd(2'(c), stat(0, 1, 3, 0, 0), "R11 reset status");
        end

        // R1 configuration sweep: every channel, mode code and BCD value
        for (int c = 0; c < 3; c++)
            for (int m = 0; m < 8; m++)
                for (int b = 0; b < 2; b++) begin
                    ctl(c, 1 + ((m + b) % 3), m, b);
                    check("R1 mode", int'(ch_mode[c]), fold(m));
                    check("R1 bcd", int'(ch_bcd[c]), b);
                end
        ch_out = 3'b101;
        for (int c = 0; c < 3; c++) begin
            wr(2'd3, 8'(8'hE0 | (2 << c)));
            rd(2'(c), stat((c == 1) ? 0 : 1, 1, 1 + ((7 + 1) % 3), 3, 1), "R7 status fields");
        end
        ch_out = 3'b000;

        // R2 single-byte loads
        for (int c = 0; c < 3; c++)
            for (int a = 1; a <= 2; a++)
                for (int k = 0; k < 3; k++) begin
                    int d;
                    d = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : 8'hFF;
                    ctl(c, a, 0, 0);
                    wr(2'(c), 8'(d));
                    check("R2 strobe", int'(ch_load), 1 << c);
                    check("R2 value", int'(ch_load_val[c]), (a == 1) ? d : (d << 8));
                    @(negedge clk);
                    check("R2 strobe one cycle", int'(ch_load), 0);
                end

        // R3 word loads
        for (int c = 0; c < 3; c++) begin
            ctl(c, 3, 2, 0);
            wr(2'(c), 8'h34);
            check("R3 no load after low", int'(ch_load), 0);
            wr(2'(c), 8'h12);
            check("R3 word strobe", int'(ch_load), 1 << c);
            check("R3 word value", int'(ch_load_val[c]), 16'h1234);
            wr(2'(c), 8'hCD);
            check("R3 back to low", int'(ch_load), 0);
            wr(2'(c), 8'hAB);
            check("R3 second word", int'(ch_load_val[c]), 16'hABCD);
        end

        // R8 live reads
        ch_count[1] = 16'hBEEF;
        ctl(1, 1, 0, 0);
        rd(2'd1, 8'hEF, "R8 low only");
        rd(2'd1, 8'hEF, "R8 low only repeat");
        ctl(1, 2, 0, 0);
        rd(2'd1, 8'hBE, "R8 high only");
        ctl(1, 3, 0, 0);
        rd(2'd1, 8'hEF, "R8 word low");
        rd(2'd1, 8'hBE, "R8 word high");
        rd(2'd1, 8'hEF, "R8 word low again");
        rd(2'd3, 0, "R8 control read");

        // R9 sequence restart on control word
        ctl(1, 3, 2, 0);
        rd(2'd1, 8'hEF, "R9 first read");
        ctl(1, 3, 2, 0);
        rd(2'd1, 8'hEF, "R9 read restarts low");
        wr(2'd1, 8'h11);
        ctl(1, 3, 2, 0);
        wr(2'd1, 8'h22);
        check("R9 write restarts low", int'(ch_load), 0);
        wr(2'd1, 8'h33);
        check("R9 word after restart", int'(ch_load_val[1]), 16'h3322);

        // R4 count freeze
        ctl(0, 3, 2, 0);
        ch_count[0] = 16'h1234;
        wr(2'd3, 8'h00);
        ch_count[0] = 16'h5555;
        rd(2'd0, 8'h34, "R4 frozen low");
        rd(2'd0, 8'h12, "R4 frozen high");
        rd(2'd0, 8'h55, "R4 live after release");
        rd(2'd0, 8'h55, "R4 live high");
        ctl(0, 2, 0, 0);
        ch_count[0] = 16'hA1B2;
        wr(2'd3, 8'h00);
        ch_count[0] = 16'hC3D4;
        rd(2'd0, 8'hA1, "R4 frozen single");
        rd(2'd0, 8'hC3, "R4 released after one");

        // R5 second request ignored while pending
        ctl(0, 3, 2, 0);
        ch_count[0] = 16'h1111;
        wr(2'd3, 8'h00);
        ch_count[0] = 16'h2222;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h11, "R5 first freeze kept low");
        rd(2'd0, 8'h11, "R5 first freeze kept high");
        rd(2'd0, 8'h22, "R5 live");
        ch_out[0] = 1'b1;
        wr(2'd3, 8'hE2);
        ch_out[0] = 1'b0;
        wr(2'd3, 8'hE2);
        rd(2'd0, stat(1, 1, 3, 2, 0), "R5 first status kept");
        rd(2'd0, 8'h22, "R5 status released");

        // R6 / R7 snapshot of channels 0 and 2
        ctl(0, 3, 2, 0);
        ctl(1, 3, 2, 0);
        ctl(2, 1, 0, 0);
        ch_count[0] = 16'h0A0B; ch_count[1] = 16'h0C0D; ch_count[2] = 16'h0E0F;
        wr(2'd3, 8'hCA);
        ch_count = {16'h9999, 16'h9999, 16'h9999};
        rd(2'd1, 8'h99, "R6 unselected channel live");
        rd(2'd0, stat(0, 1, 3, 2, 0), "R7 status first");
        rd(2'd0, 8'h0B, "R7 frozen low after status");
        rd(2'd0, 8'h0A, "R7 frozen high");
        rd(2'd0, 8'h99, "R7 live last");
        rd(2'd2, stat(0, 1, 1, 0, 0), "R6 channel 2 status");
        rd(2'd2, 8'h0F, "R6 channel 2 frozen");
        rd(2'd2, 8'h99, "R6 channel 2 live");
        ch_count[0] = 16'h4321;
        wr(2'd3, 8'hD2);
        ch_count[0] = 16'h0000;
        rd(2'd0, 8'h21, "R6 count only low");
        rd(2'd0, 8'h43, "R6 count only high");
        ch_count[0] = 16'h7788;
        wr(2'd3, 8'hE2);
        rd(2'd0, stat(0, 1, 3, 2, 0), "R6 status only");
        rd(2'd0, 8'h77, "R6 status only froze no count");

        // R10 null-count flag
        ctl(0, 1, 0, 0);
        wr(2'd0, 8'h05);
        pulse_loaded(0);
        wr(2'd3, 8'hE2);
        rd(2'd0, stat(0, 0, 1, 0, 0), "R10 cleared by loaded");
        ch_loaded[0] = 1'b1;
        wr(2'd0, 8'h06);
        ch_loaded[0] = 1'b0;
        wr(2'd3, 8'hE2);
        rd(2'd0, stat(0, 1, 1, 0, 0), "R10 set wins same cycle");
        pulse_loaded(0);
        ch_loaded[0] = 1'b1;
        ctl(0, 1, 0, 0);
        ch_loaded[0] = 1'b0;
        wr(2'd3, 8'hE2);
        rd(2'd0, stat(0, 1, 1, 0, 0), "R10 control word sets");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule